// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus and turns one high-level request into the full bus activity the flash needs. A request is one of three kinds: program one byte, erase one sector, or erase the whole array. It is accepted on a valid/ready handshake. The sequencer then plays out the unlock-and-command write cycles for that request. Every write cycle is strobed with chip-enable held low and a timed write-enable pulse.

Once the write that starts the internal operation has finished, the block polls the target location with timed read cycles. It watches the toggling status bit and compares the data-polling bit with its expected value. A status read can coincide with the end of the internal operation and give a false answer, so a read that looks like completion is never trusted alone. It must be followed by two more reads that also look complete. If the operation never settles, a timeout counter ends polling. The result is a one-clock done pulse with a success flag or a timeout flag.

Top module: `flash_wr_seq`

## Requirements
- R1: Out of reset, req_ready is 1, flash_ce_n, flash_we_n and flash_oe_n are 1, flash_dq_oe is 0 and done is 0.
- R2: Request code req_op = 0 is a byte program. It produces exactly four write cycles, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (req_addr, req_data).
- R3: req_op = 1 is a sector erase. It produces exactly six write cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (req_addr with its low SECT_BITS bits cleared, 30h).
- R4: req_op = 2 is a chip erase, and req_op = 3 behaves the same way. Both produce the same first five write cycles as R3, followed by (5555h, 10h).
- R5: flash_we_n goes low only while flash_ce_n is low and flash_oe_n is high. flash_addr does not change while flash_we_n is low. At the rising edge of flash_we_n, flash_dq_oe is 1 and flash_dq_out is unchanged. flash_ce_n returns high after every bus cycle.
- R6: A read cycle holds flash_ce_n and flash_oe_n low with flash_we_n high and flash_dq_oe 0, and always addresses req_addr. The first read starts only after all the write cycles of the request have completed. No write cycle occurs once reading has begun.
- R7: A status read is valid when its bit 7 equals the expected value and its bit 6 equals bit 6 of the previous status read. The expected bit-7 value is req_data bit 7 for a program and 1 for either erase. The first read of a request only sets the baseline. Success is declared on the third valid read in a row: one read suggesting completion plus two confirmations. Any invalid read restarts the count.
- R8: If TMO_CLK clocks of polling pass without success, the request ends at the next read with done_tmo = 1 and done_ok = 0.
- R9: done is a one-clock pulse. Exactly one of done_ok and done_tmo is 1 with it. Both flags hold until the next request is accepted, and req_ready is 1 in the cycle of done.
- R10: req_ready is 0 from acceptance until done. A req_valid raised during that time causes no bus cycle and is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | AW | Target byte or sector address; also the polling address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-clock completion pulse |
| done_ok | output | 1 | Operation finished and confirmed |
| done_tmo | output | 1 | Polling gave up after TMO_CLK clocks |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 8 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Enable for the host data drivers |
| flash_dq_in | input | 8 | Data returned by the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The checks assume that the device model only places meaningful data on flash_dq_in after output-enable falls, and that it keeps that data steady until the sequencer samples it. They also assume that req_op, req_addr and req_data are steady while req_valid is high. The bench model changes the returned byte only at the falling edge of flash_oe_n. It raises a request only while req_ready is high, except in one deliberate test that holds req_valid high during polling to show that the request is not taken. Each status pattern is chosen so that the number of reads to success follows directly from the validity rule: a plain busy period, spurious completions in the middle of busy, an immediate finish, and a device that never finishes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG     = 2'd0,
    OP_SECT     = 2'd1,
    OP_CHIP     = 2'd2,
    OP_CHIP_ALT = 2'd3
  } fseq_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WR,
    SQ_WR_WAIT,
    SQ_RD,
    SQ_RD_WAIT
  } fseq_state_e;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_SETUP,
    BC_PULSE,
    BC_HOLD,
    BC_READ
  } bc_phase_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;

  localparam logic [7:0] CD_KEY1  = 8'hAA;
  localparam logic [7:0] CD_KEY2  = 8'h55;
  localparam logic [7:0] CD_PROG  = 8'hA0;
  localparam logic [7:0] CD_ERASE = 8'h80;
  localparam logic [7:0] CD_SECT  = 8'h30;
  localparam logic [7:0] CD_CHIP  = 8'h10;

  localparam int STEP_W = 3;

endpackage

// File: rtl/fseq_cmd_table.sv
// Computes the address/data of each write step of a request; no storage.
module fseq_cmd_table
  import fseq_pkg::*;
#(
  parameter int AW        = 18,
  parameter int SECT_BITS = 12
) (
  input  logic [1:0]        op,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic [AW-1:0]     cyc_addr,
  output logic [7:0]        cyc_data,
  output logic              cyc_last
);

  localparam logic [AW-1:0] A_ONE = AW'(UNLOCK_A);
  localparam logic [AW-1:0] A_TWO = AW'(UNLOCK_B);

  logic          is_prog;
  logic [AW-1:0] sect_base;

  assign is_prog = (op == OP_PROG);

  generate
    if (SECT_BITS > 0) begin : g_mask
      assign sect_base = {tgt_addr[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
    end else begin : g_nomask
      assign sect_base = tgt_addr;
    end
  endgenerate

  always_comb begin
    cyc_addr = A_ONE;
    cyc_data = CD_KEY1;
    unique case (step)
      3'd0: begin cyc_addr = A_ONE; cyc_data = CD_KEY1; end
      3'd1: begin cyc_addr = A_TWO; cyc_data = CD_KEY2; end
      3'd2: begin cyc_addr = A_ONE; cyc_data = is_prog ? CD_PROG : CD_ERASE; end
      3'd3: begin
        cyc_addr = is_prog ? tgt_addr : A_ONE;
        cyc_data = is_prog ? tgt_data : CD_KEY1;
      end
      3'd4: begin cyc_addr = A_TWO; cyc_data = CD_KEY2; end
      3'd5: begin
        if (op == OP_SECT) begin
          cyc_addr = sect_base;
          cyc_data = CD_SECT;
        end else begin
          cyc_addr = A_ONE;
          cyc_data = CD_CHIP;
        end
      end
      default: begin cyc_addr = A_ONE; cyc_data = CD_KEY1; end
    endcase
  end

  assign cyc_last = is_prog ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/fseq_bus_cycle.sv
// Runs one write or one read cycle on the flash pins; all pins registered.
module fseq_bus_cycle
  import fseq_pkg::*;
#(
  parameter int AW        = 18,
  parameter int SETUP_CLK = 1,
  parameter int PULSE_CLK = 3,
  parameter int HOLD_CLK  = 1,
  parameter int ACC_CLK   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic [7:0]    dq_in,
  output logic          cyc_done,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] pin_addr,
  output logic [7:0]    pin_dq,
  output logic          pin_dq_oe,
  output logic          pin_ce_n,
  output logic          pin_we_n,
  output logic          pin_oe_n
);

  localparam int MAX_AB = (SETUP_CLK > PULSE_CLK) ? SETUP_CLK : PULSE_CLK;
  localparam int MAX_CD = (HOLD_CLK > ACC_CLK) ? HOLD_CLK : ACC_CLK;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  bc_phase_e     ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= BC_IDLE;
      cnt       <= '0;
      cyc_done  <= 1'b0;
      rd_data   <= '0;
      pin_addr  <= '0;
      pin_dq    <= '0;
      pin_dq_oe <= 1'b0;
      pin_ce_n  <= 1'b1;
      pin_we_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
    end else begin
      cyc_done <= 1'b0;
      unique case (ph)
        BC_IDLE: begin
          if (start) begin
            pin_addr <= addr_in;
            pin_ce_n <= 1'b0;
            if (is_read) begin
              ph        <= BC_READ;
              pin_oe_n  <= 1'b0;
              pin_dq_oe <= 1'b0;
              cnt       <= CW'(ACC_CLK - 1);
            end else begin
              ph        <= BC_SETUP;
              pin_dq    <= data_in;
              pin_dq_oe <= 1'b1;
              cnt       <= CW'(SETUP_CLK - 1);
            end
          end
        end
        BC_SETUP: begin
          if (cnt == '0) begin
            ph       <= BC_PULSE;
            pin_we_n <= 1'b0;
            cnt      <= CW'(PULSE_CLK - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_PULSE: begin
          if (cnt == '0) begin
            ph       <= BC_HOLD;
            pin_we_n <= 1'b1;
            cnt      <= CW'(HOLD_CLK - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_HOLD: begin
          if (cnt == '0) begin
            ph        <= BC_IDLE;
            pin_ce_n  <= 1'b1;
            pin_dq_oe <= 1'b0;
            cyc_done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_READ: begin
          if (cnt == '0) begin
            ph       <= BC_IDLE;
            rd_data  <= dq_in;
            pin_ce_n <= 1'b1;
            pin_oe_n <= 1'b1;
            cyc_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= BC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_timeout.sv
// Counts polling clocks; expired sticks until cleared.
module fseq_timeout #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run && !expired) begin
      if (cnt == TW'(LIMIT - 1)) expired <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import fseq_pkg::*;
#(
  parameter int AW        = 18,
  parameter int SECT_BITS = 12,
  parameter int SETUP_CLK = 1,
  parameter int PULSE_CLK = 3,
  parameter int HOLD_CLK  = 1,
  parameter int ACC_CLK   = 3,
  parameter int TMO_CLK   = 2000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          done,
  output logic          done_ok,
  output logic          done_tmo,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_dq_in,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n
);

  localparam int CONFIRM_N = 2;
  localparam int STREAK_W  = $clog2(CONFIRM_N + 2);

  fseq_state_e         st;
  logic [1:0]          op_q;
  logic [AW-1:0]       addr_q;
  logic [7:0]          data_q;
  logic [STEP_W-1:0]   step;
  logic [STREAK_W-1:0] streak;
  logic                prev6;
  logic                have_prev;
  logic                bus_start;
  logic                tmo_clear;
  logic                tmo_hit;

  logic [AW-1:0] tbl_addr;
  logic [7:0]    tbl_data;
  logic          tbl_last;
  logic          bus_done;
  logic [7:0]    rd_data;
  logic          bus_is_read;
  logic [AW-1:0] bus_addr;
  logic          exp7;
  logic          rd_valid;
  logic          unused_rd_bits;

  assign req_ready      = (st == SQ_IDLE);
  assign bus_is_read    = (st == SQ_RD_WAIT);
  assign bus_addr       = bus_is_read ? addr_q : tbl_addr;
  assign exp7           = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign rd_valid       = have_prev && (rd_data[7] == exp7) && (rd_data[6] == prev6);
  assign unused_rd_bits = ^rd_data[5:0];

  fseq_cmd_table #(
    .AW        (AW),
    .SECT_BITS (SECT_BITS)
  ) u_tbl (
    .op       (op_q),
    .step     (step),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (tbl_addr),
    .cyc_data (tbl_data),
    .cyc_last (tbl_last)
  );

  fseq_bus_cycle #(
    .AW        (AW),
    .SETUP_CLK (SETUP_CLK),
    .PULSE_CLK (PULSE_CLK),
    .HOLD_CLK  (HOLD_CLK),
    .ACC_CLK   (ACC_CLK)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .start     (bus_start),
    .is_read   (bus_is_read),
    .addr_in   (bus_addr),
    .data_in   (tbl_data),
    .dq_in     (flash_dq_in),
    .cyc_done  (bus_done),
    .rd_data   (rd_data),
    .pin_addr  (flash_addr),
    .pin_dq    (flash_dq_out),
    .pin_dq_oe (flash_dq_oe),
    .pin_ce_n  (flash_ce_n),
    .pin_we_n  (flash_we_n),
    .pin_oe_n  (flash_oe_n)
  );

  fseq_timeout #(
    .LIMIT (TMO_CLK)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmo_clear),
    .run     ((st == SQ_RD) || (st == SQ_RD_WAIT)),
    .expired (tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      step      <= '0;
      streak    <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      bus_start <= 1'b0;
      tmo_clear <= 1'b0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
      done_tmo  <= 1'b0;
    end else begin
      done      <= 1'b0;
      bus_start <= 1'b0;
      tmo_clear <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            op_q      <= req_op;
            addr_q    <= req_addr;
            data_q    <= req_data;
            step      <= '0;
            done_ok   <= 1'b0;
            done_tmo  <= 1'b0;
            tmo_clear <= 1'b1;
            st        <= SQ_WR;
          end
        end
        SQ_WR: begin
          bus_start <= 1'b1;
          st        <= SQ_WR_WAIT;
        end
        SQ_WR_WAIT: begin
          if (bus_done) begin
            if (tbl_last) begin
              have_prev <= 1'b0;
              streak    <= '0;
              st        <= SQ_RD;
            end else begin
              step <= step + 1'b1;
              st   <= SQ_WR;
            end
          end
        end
        SQ_RD: begin
          bus_start <= 1'b1;
          st        <= SQ_RD_WAIT;
        end
        SQ_RD_WAIT: begin
          if (bus_done) begin
            prev6     <= rd_data[6];
            have_prev <= 1'b1;
            if (rd_valid && (streak == STREAK_W'(CONFIRM_N))) begin
              done    <= 1'b1;
              done_ok <= 1'b1;
              st      <= SQ_IDLE;
            end else if (tmo_hit) begin
              done     <= 1'b1;
              done_tmo <= 1'b1;
              st       <= SQ_IDLE;
            end else begin
              streak <= rd_valid ? streak + 1'b1 : '0;
              st     <= SQ_RD;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic          done,
  input logic          done_ok,
  input logic          done_tmo,
  input logic [AW-1:0] flash_addr,
  input logic [7:0]    flash_dq_out,
  input logic          flash_dq_oe,
  input logic          flash_ce_n,
  input logic          flash_we_n,
  input logic          flash_oe_n
);

  logic [3:0] wcnt;
  logic       polling;
  logic [1:0] opq;
  logic       we_q;
  logic       oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      polling <= 1'b0;
      opq     <= '0;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
    end else begin
      we_q <= flash_we_n;
      oe_q <= flash_oe_n;
      if (req_valid && req_ready) begin
        wcnt    <= '0;
        polling <= 1'b0;
        opq     <= req_op;
      end else begin
        if (we_q && !flash_we_n) wcnt <= wcnt + 1'b1;
        if (oe_q && !flash_oe_n) polling <= 1'b1;
      end
    end
  end

  // R5
  we_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flash_we_n && !we_q) |-> $stable(flash_addr));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_we_n) |-> (flash_dq_oe && $stable(flash_dq_out)));

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> (!flash_dq_oe && !flash_ce_n && flash_we_n));

  // R6
  poll_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_oe_n) |-> (wcnt == ((opq == 2'd0) ? 4'd4 : 4'd6)));

  // R6
  no_wr_in_poll_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_we_n) |-> !polling);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (($countones({done_ok, done_tmo}) == 1) && req_ready));

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind flash_wr_seq fseq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .done         (done),
  .done_ok      (done_ok),
  .done_tmo     (done_tmo),
  .flash_addr   (flash_addr),
  .flash_dq_out (flash_dq_out),
  .flash_dq_oe  (flash_dq_oe),
  .flash_ce_n   (flash_ce_n),
  .flash_we_n   (flash_we_n),
  .flash_oe_n   (flash_oe_n)
);

// File: tb/sim_flash_wr_seq.sv
`timescale 1ns/1ps
module sim_flash_wr_seq;

  localparam int AW  = 18;
  localparam int TMO = 600;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, done_ok, done_tmo;
  logic [AW-1:0] flash_addr;
  logic [7:0]    flash_dq_out;
  logic          flash_dq_oe;
  logic [7:0]    flash_dq_in = '0;
  logic          flash_ce_n, flash_we_n, flash_oe_n;

  always #2.5 clk = ~clk;

  flash_wr_seq #(
    .AW(AW), .SECT_BITS(12), .SETUP_CLK(1), .PULSE_CLK(2),
    .HOLD_CLK(1), .ACC_CLK(2), .TMO_CLK(TMO)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .done_ok(done_ok), .done_tmo(done_tmo),
    .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .flash_oe_n(flash_oe_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  // device model state
  int         m_busy = 0;
  int         m_ga = 0;
  int         m_gb = 0;
  logic [7:0] m_final = 8'hFF;
  logic       m_exp7 = 1'b1;
  int         rd_idx = 0;
  int         wr_cnt = 0;
  int         ce_rise = 0;
  int         wr_oe_bad = 0;
  logic [AW-1:0] wa [8];
  logic [7:0]    wd [8];

  // busy reads: bit7 opposite of expected, bit6 toggles starting at 0
  always @(negedge flash_oe_n) begin
    rd_idx = rd_idx + 1;
    if (rd_idx > m_busy || rd_idx == m_ga || rd_idx == m_gb)
      flash_dq_in = m_final;
    else
      flash_dq_in = {~m_exp7, ((rd_idx - 1) % 2) == 1, 6'h15};
  end

  always @(posedge flash_we_n) begin
    if (!rst) begin
      if (wr_cnt < 8) begin
        wa[wr_cnt] = flash_addr;
        wd[wr_cnt] = flash_dq_out;
      end
      if (!flash_dq_oe) wr_oe_bad = wr_oe_bad + 1;
      wr_cnt = wr_cnt + 1;
    end
  end

  always @(posedge flash_ce_n) begin
    if (!rst) ce_rise = ce_rise + 1;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  function automatic logic [AW+7:0] exp_w(input logic [1:0] op, input int s,
                                          input logic [AW-1:0] a, input logic [7:0] d);
    case (s)
      0: return {18'h05555, 8'hAA};
      1: return {18'h02AAA, 8'h55};
      2: return (op == 2'd0) ? {18'h05555, 8'hA0} : {18'h05555, 8'h80};
      3: return (op == 2'd0) ? {a, d} : {18'h05555, 8'hAA};
      4: return {18'h02AAA, 8'h55};
      default: return (op == 2'd1) ? {a & 18'h3F000, 8'h30} : {18'h05555, 8'h10};
    endcase
  endfunction

  // reads until success per R7, for a busy period of n reads
  function automatic int exp_reads(input int n, input logic final6);
    if (n == 0) return 4;
    if ((((n - 1) % 2) == 1) == final6) return n + 3;
    return n + 4;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int n, input int ga, input int gb, input bit want_tmo,
                        input string tag);
    int nw;
    int cyc;
    bit wr_ok;
    m_final = (op == 2'd0) ? d : 8'hFF;
    m_exp7  = (op == 2'd0) ? d[7] : 1'b1;
    m_busy = n; m_ga = ga; m_gb = gb;
    rd_idx = 0; wr_cnt = 0; ce_rise = 0; wr_oe_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    nw = (op == 2'd0) ? 4 : 6;
    chk(wr_cnt == nw, (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4",
        {tag, " write count"}, wr_cnt, nw);
    wr_ok = 1'b1;
    for (int i = 0; i < nw && i < 8; i++)
      if ({wa[i], wd[i]} != exp_w(op, i, a, d)) wr_ok = 1'b0;
    chk(wr_ok, (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : "R4",
        {tag, " write addr/data"}, wr_ok, 1);
    chk(wr_oe_bad == 0, "R5", {tag, " data driven at we rise"}, wr_oe_bad, 0);
    chk(ce_rise == wr_cnt + rd_idx, "R5", {tag, " ce high after each cycle"},
        ce_rise, wr_cnt + rd_idx);
    if (want_tmo) begin
      chk(done && done_tmo && !done_ok, "R8", {tag, " timeout flags"},
          {done, done_ok, done_tmo}, 3'b101);
      chk(rd_idx > 2, "R8", {tag, " polled before timeout"}, rd_idx, 3);
    end else begin
      chk(done && done_ok && !done_tmo, "R7", {tag, " success flags"},
          {done, done_ok, done_tmo}, 3'b110);
      chk(rd_idx == exp_reads(n, m_final[6]), "R7", {tag, " read count"},
          rd_idx, exp_reads(n, m_final[6]));
    end
  endtask

  // {op, addr, data, busy reads}
  localparam logic [35:0] VECS [0:6] = '{
    {2'd0, 18'h12345, 8'hC5, 8'd5},
    {2'd0, 18'h00000, 8'h3A, 8'd0},
    {2'd1, 18'h27ABC, 8'h00, 8'd6},
    {2'd2, 18'h00000, 8'h00, 8'd3},
    {2'd0, 18'h3FFFF, 8'h40, 8'd2},
    {2'd1, 18'h01FFF, 8'h00, 8'd1},
    {2'd3, 18'h00123, 8'h00, 8'd4}
  };

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(req_ready && flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe && !done,
        "R1", "reset outputs",
        {req_ready, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done}, 6'b111100);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && flash_ce_n && flash_we_n && flash_oe_n && !flash_dq_oe && !done,
        "R1", "idle after reset",
        {req_ready, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe, done}, 6'b111100);

    for (int v = 0; v < 7; v++)
      run_op(VECS[v][35:34], VECS[v][33:16], VECS[v][15:8], int'(VECS[v][7:0]),
             0, 0, 1'b0, $sformatf("vec%0d", v));

    // R7: two spurious completions inside busy must not finish the request
    run_op(2'd0, 18'h00456, 8'hC5, 8, 3, 4, 1'b0, "glitch");

    // R9: pulse width and held flags
    @(negedge clk);
    chk(!done && done_ok && !done_tmo, "R9", "one-clock done, flag held",
        {done, done_ok, done_tmo}, 3'b010);

    // R8: device never finishes
    run_op(2'd1, 18'h05000, 8'h00, 1000000, 0, 0, 1'b1, "timeout");
    @(negedge clk);
    chk(!done && done_tmo && !done_ok, "R9", "timeout flag held",
        {done, done_ok, done_tmo}, 3'b001);

    // R10: request raised during polling is not taken
    begin
      int busy_ready;
      int cyc;
      m_final = 8'h7E; m_exp7 = 1'b0; m_busy = 12; m_ga = 0; m_gb = 0;
      rd_idx = 0; wr_cnt = 0; ce_rise = 0; wr_oe_bad = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 18'h00777; req_data = 8'h7E;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (rd_idx < 2 && cyc < 2000) begin @(negedge clk); cyc++; end
      busy_ready = 0;
      req_valid = 1'b1; req_op = 2'd2;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (req_ready) busy_ready++;
      end
      req_valid = 1'b0;
      chk(busy_ready == 0, "R10", "ready low while busy", busy_ready, 0);
      cyc = 0;
      while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
      chk(wr_cnt == 4, "R10", "no extra writes from ignored request", wr_cnt, 4);
      chk(done && done_ok, "R10", "original request completes", {done, done_ok}, 2'b11);
      @(negedge clk);
      chk(req_ready && flash_ce_n, "R10", "idle afterwards", {req_ready, flash_ce_n}, 2'b11);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule